// File: doc/BRIEF.md
# Serial Receive Interrupt Controller

This block decides when a serial receiver asks the host CPU for service and which cause it reports. Each received character arrives as a one-cycle strobe. The strobe carries the receive FIFO fill level, counted after that character was written, and four error flags for the character. A two-bit policy select chooses one of four policies. The first policy interrupts once on the first character and then reports errors only. The second interrupts on every character, optionally only once a fill threshold is reached. The third interrupts on error characters only. The fourth turns the receive interrupts off.

A character-available cause and a special (error) cause raise the same request line. They differ only in the two-bit vector status the host reads while acknowledging. A special cause stays pending until the host issues an error-reset command. A character cause is cleared by an acknowledge that arrives while no special cause is pending. In first-character policy, a latch remembers that the first character has been reported. The latch is re-armed by a reset-first command or by disabling the receiver.

Top module: `rx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all pending causes and the first-character latch clear, so `irq` is 0 and `vec_status` is 2'b00 after that edge.
- R2: With policy 2'b10 (every character) and `thresh_en` = 0, a strobe with no error sets a character cause. From the next cycle `vec_status` is 2'b01 and `irq` is 1.
- R3: With policy 2'b10 and `thresh_en` = 1, a strobe sets a character cause only if `fifo_level` at the strobe is at least THRESH (default 4).
- R4: With policy 2'b01 (first character), the first strobe after arming sets a character cause and sets the latch. Later strobes set no character cause while the latch is set.
- R5: The latch is cleared by a `cmd_reset_first` pulse or by any cycle with `rx_enable` low. The next strobe then sets a character cause again.
- R6: With policy 2'b11 (special only), a strobe never sets a character cause. A strobe carrying an enabled error sets a special cause, reported as `vec_status` 2'b10.
- R7: Any of `err_overrun`, `err_framing` or `err_eof` on a strobe makes a special cause. `err_parity` makes one only while `parity_en` = 1. With `parity_en` = 0, the parity flag has no effect.
- R8: When a special cause and a character cause are both pending, `vec_status` is 2'b10.
- R9: A special cause stays pending through acknowledges and further strobes until `cmd_reset_err`. After that, a character cause that is still pending is reported as 2'b01.
- R10: `int_ack` clears the character cause when no special cause is pending, and `irq` is 0 in the cycle after that edge. `irq` is 1 exactly when `vec_status` is not 2'b00, and `vec_status` is never 2'b11.
- R11: Strobes have no effect while `rx_enable` is 0 or while the policy is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receiver enabled; low re-arms the first-character latch |
| rx_mode | input | 2 | Policy: 00 off, 01 first character, 10 every character, 11 special only |
| thresh_en | input | 1 | Require FIFO fill of THRESH in every-character policy |
| parity_en | input | 1 | Let parity errors count as special causes |
| char_strobe | input | 1 | One-cycle pulse per received character |
| fifo_level | input | $clog2(FIFO_DEPTH+1) | FIFO fill level including the strobed character |
| err_overrun | input | 1 | Overrun flag for the strobed character |
| err_framing | input | 1 | Framing error flag for the strobed character |
| err_eof | input | 1 | End-of-frame flag for the strobed character |
| err_parity | input | 1 | Parity error flag for the strobed character |
| cmd_reset_first | input | 1 | Re-arm the first-character latch |
| cmd_reset_err | input | 1 | Clear the pending special cause |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| vec_status | output | 2 | 00 none, 01 character available, 10 special condition |

## Verification
The bench builds the block with its defaults: FIFO_DEPTH 8, THRESH 4 and the parity source included. A fill level sweep from 0 to 8 therefore reaches both sides of the threshold and a full FIFO. Every combination of policy, threshold enable, parity enable, the four error flags and the nine fill levels is applied from a clean state. Each combination is followed by a two-step clear that exposes a hidden character cause. Directed sequences cover latch re-arming, special-cause persistence and reset.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
   typedef enum logic [1:0] {
      RM_OFF   = 2'b00,
      RM_FIRST = 2'b01,
      RM_ALL   = 2'b10,
      RM_SPEC  = 2'b11
   } rx_mode_e;

   typedef enum logic [1:0] {
      VS_NONE = 2'b00,
      VS_CHAR = 2'b01,
      VS_SPEC = 2'b10
   } vec_stat_e;

   typedef struct packed {
      logic ovr;
      logic frm;
      logic eof;
      logic par;
   } rx_err_t;
endpackage

// File: rtl/rxi_cond_detect.sv
module rxi_cond_detect
   import rxi_pkg::*;
#(
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic    strobe_ok,
   input  logic    policy_on,
   input  rx_err_t errs,
   input  logic    parity_en,
   output logic    spec_hit
);
   logic par_term;

   generate
      if (HAS_PARITY) begin : g_par
         assign par_term = errs.par & parity_en;
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = errs.par ^ parity_en;
         assign par_term   = 1'b0;
      end
   endgenerate

   assign spec_hit = strobe_ok & policy_on & (errs.ovr | errs.frm | errs.eof | par_term);
endmodule

// File: rtl/rxi_char_policy.sv
module rxi_char_policy
   import rxi_pkg::*;
#(
   parameter int LVL_W  = 4,
   parameter int THRESH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_enable,
   input  rx_mode_e         mode,
   input  logic             thresh_en,
   input  logic             strobe_ok,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             cmd_reset_first,
   output logic             char_hit
);
   localparam logic [LVL_W-1:0] THR_L = LVL_W'(THRESH);

   logic first_seen;
   logic level_ok;

   assign level_ok = ~thresh_en | (fifo_level >= THR_L);

   always_comb begin
      unique case (mode)
         RM_FIRST: char_hit = strobe_ok & ~first_seen;
         RM_ALL:   char_hit = strobe_ok & level_ok;
         default:  char_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_seen <= 1'b0;
      end else if (!rx_enable) begin
         first_seen <= 1'b0;
      end else if (mode == RM_FIRST && strobe_ok) begin
         first_seen <= 1'b1;
      end else if (cmd_reset_first) begin
         first_seen <= 1'b0;
      end
   end
endmodule

// File: rtl/rxi_pend.sv
module rxi_pend
   import rxi_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      char_hit,
   input  logic      spec_hit,
   input  logic      int_ack,
   input  logic      cmd_reset_err,
   output logic      irq,
   output vec_stat_e status
);
   logic ca_pend;
   logic sc_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ca_pend <= 1'b0;
         sc_pend <= 1'b0;
      end else begin
         if (char_hit)
            ca_pend <= 1'b1;
         else if (int_ack && !sc_pend)
            ca_pend <= 1'b0;

         if (spec_hit)
            sc_pend <= 1'b1;
         else if (cmd_reset_err)
            sc_pend <= 1'b0;
      end
   end

   always_comb begin
      if (sc_pend)      status = VS_SPEC;
      else if (ca_pend) status = VS_CHAR;
      else              status = VS_NONE;
   end

   assign irq = ca_pend | sc_pend;
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
   import rxi_pkg::*;
#(
   parameter int  FIFO_DEPTH = 8,
   parameter int  THRESH     = 4,
   parameter bit  HAS_PARITY = 1'b1,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_enable,
   input  logic [1:0]       rx_mode,
   input  logic             thresh_en,
   input  logic             parity_en,
   input  logic             char_strobe,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             err_overrun,
   input  logic             err_framing,
   input  logic             err_eof,
   input  logic             err_parity,
   input  logic             cmd_reset_first,
   input  logic             cmd_reset_err,
   input  logic             int_ack,
   output logic             irq,
   output logic [1:0]       vec_status
);
   generate
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
      if (THRESH < 1 || THRESH > FIFO_DEPTH) begin : g_bad_thresh
         $error("THRESH must lie in 1..FIFO_DEPTH");
      end
   endgenerate

   rx_mode_e  mode;
   rx_err_t   errs;
   logic      strobe_ok;
   logic      policy_on;
   logic      char_hit;
   logic      spec_hit;
   vec_stat_e status;

   assign mode      = rx_mode_e'(rx_mode);
   assign errs      = '{ovr: err_overrun, frm: err_framing, eof: err_eof, par: err_parity};
   assign strobe_ok = char_strobe & rx_enable;
   assign policy_on = (mode != RM_OFF);

   rxi_cond_detect #(.HAS_PARITY(HAS_PARITY)) u_cond (
      .strobe_ok (strobe_ok),
      .policy_on (policy_on),
      .errs      (errs),
      .parity_en (parity_en),
      .spec_hit  (spec_hit)
   );

   rxi_char_policy #(.LVL_W(LVL_W), .THRESH(THRESH)) u_char (
      .clk             (clk),
      .rst_n           (rst_n),
      .rx_enable       (rx_enable),
      .mode            (mode),
      .thresh_en       (thresh_en),
      .strobe_ok       (strobe_ok),
      .fifo_level      (fifo_level),
      .cmd_reset_first (cmd_reset_first),
      .char_hit        (char_hit)
   );

   rxi_pend u_pend (
      .clk           (clk),
      .rst_n         (rst_n),
      .char_hit      (char_hit),
      .spec_hit      (spec_hit),
      .int_ack       (int_ack),
      .cmd_reset_err (cmd_reset_err),
      .irq           (irq),
      .status        (status)
   );

   assign vec_status = status;
endmodule

// File: rtl/rxi_chk.sv
module rxi_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_enable,
   input logic [1:0] rx_mode,
   input logic       char_strobe,
   input logic       err_overrun,
   input logic       err_framing,
   input logic       err_eof,
   input logic       cmd_reset_err,
   input logic       int_ack,
   input logic       irq,
   input logic [1:0] vec_status
);
   // R10
   irq_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (vec_status != 2'b00));

   // R10
   no_illegal_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_status != 2'b11);

   // R9
   spec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_status == 2'b10 && !cmd_reset_err) |=> vec_status == 2'b10);

   // R10
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_status == 2'b01 && int_ack && !char_strobe) |=> vec_status == 2'b00);

   // R11
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_status == 2'b00 && (!char_strobe || !rx_enable || rx_mode == 2'b00))
      |=> vec_status == 2'b00);

   // R8
   spec_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_strobe && rx_enable && rx_mode != 2'b00 && (err_overrun || err_framing || err_eof))
      |=> vec_status == 2'b10);
endmodule

bind rx_irq_ctrl rxi_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_enable     (rx_enable),
   .rx_mode       (rx_mode),
   .char_strobe   (char_strobe),
   .err_overrun   (err_overrun),
   .err_framing   (err_framing),
   .err_eof       (err_eof),
   .cmd_reset_err (cmd_reset_err),
   .int_ack       (int_ack),
   .irq           (irq),
   .vec_status    (vec_status)
);

// File: tb/sim_rx_irq_ctrl.sv
`timescale 1ns/1ps
module sim_rx_irq_ctrl;
   localparam int DEPTH = 8;
   localparam int THR   = 4;
   localparam int LW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_enable = 1'b0;
   logic [1:0]    rx_mode = 2'b00;
   logic          thresh_en = 1'b0;
   logic          parity_en = 1'b0;
   logic          char_strobe = 1'b0;
   logic [LW-1:0] fifo_level = '0;
   logic          err_overrun = 1'b0;
   logic          err_framing = 1'b0;
   logic          err_eof = 1'b0;
   logic          err_parity = 1'b0;
   logic          cmd_reset_first = 1'b0;
   logic          cmd_reset_err = 1'b0;
   logic          int_ack = 1'b0;
   logic          irq;
   logic [1:0]    vec_status;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   rx_irq_ctrl #(.FIFO_DEPTH(DEPTH), .THRESH(THR), .HAS_PARITY(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_mode(rx_mode),
      .thresh_en(thresh_en), .parity_en(parity_en), .char_strobe(char_strobe),
      .fifo_level(fifo_level), .err_overrun(err_overrun), .err_framing(err_framing),
      .err_eof(err_eof), .err_parity(err_parity), .cmd_reset_first(cmd_reset_first),
      .cmd_reset_err(cmd_reset_err), .int_ack(int_ack), .irq(irq), .vec_status(vec_status)
   );

   task automatic check(input string tag, input logic [1:0] exp);
      n_chk++;
      if (vec_status !== exp || irq !== (exp != 2'b00)) begin
         n_bad++;
         $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
                  tag, vec_status, irq, exp, (exp != 2'b00));
      end
   endtask

   // one clock: inputs applied at negedge, outputs sampled 1 ns after posedge
   task automatic cyc(input logic stb, input int lvl, input logic [3:0] e,
                      input logic ack, input logic rerr, input logic rfirst);
      @(negedge clk);
      char_strobe     = stb;
      fifo_level      = LW'(lvl);
      {err_overrun, err_framing, err_eof, err_parity} = e;
      int_ack         = ack;
      cmd_reset_err   = rerr;
      cmd_reset_first = rfirst;
      @(posedge clk);
      #1;
      char_strobe = 1'b0; fifo_level = '0;
      {err_overrun, err_framing, err_eof, err_parity} = 4'b0;
      int_ack = 1'b0; cmd_reset_err = 1'b0; cmd_reset_first = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      #1 check("R1 reset", 2'b00);
      @(negedge clk) rst_n = 1'b1; rx_enable = 1'b1;

      // R2 then R1 mid-run reset
      rx_mode = 2'b10;
      cyc(1, 1, 4'b0000, 0, 0, 0); check("R2 every char", 2'b01);
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk); #1 check("R1 reset clears pending", 2'b00);
      @(negedge clk) rst_n = 1'b1;

      // R4: first-character latch
      rx_mode = 2'b01;
      cyc(1, 1, 4'b0000, 0, 0, 0); check("R4 first char", 2'b01);
      cyc(0, 0, 4'b0000, 1, 0, 0); check("R10 ack clears", 2'b00);
      cyc(1, 2, 4'b0000, 0, 0, 0); check("R4 second char silent", 2'b00);
      cyc(1, 3, 4'b0000, 0, 0, 0); check("R4 third char silent", 2'b00);
      cyc(1, 4, 4'b0010, 0, 0, 0); check("R6 special after first char", 2'b10);
      cyc(0, 0, 4'b0000, 0, 1, 0); check("R9 reset err", 2'b00);

      // R5: re-arm by command and by disable
      cyc(0, 0, 4'b0000, 0, 0, 1); check("R5 reset-first no irq", 2'b00);
      cyc(1, 1, 4'b0000, 0, 0, 0); check("R5 rearmed by command", 2'b01);
      cyc(0, 0, 4'b0000, 1, 0, 0);
      @(negedge clk) rx_enable = 1'b0;
      @(negedge clk) rx_enable = 1'b1;
      cyc(1, 1, 4'b0000, 0, 0, 0); check("R5 rearmed by disable", 2'b01);
      cyc(0, 0, 4'b0000, 1, 0, 0); check("R10 ack", 2'b00);

      // R11: disabled receiver and off policy
      rx_mode = 2'b10;
      @(negedge clk) rx_enable = 1'b0;
      cyc(1, 8, 4'b1111, 0, 0, 0); check("R11 receiver disabled", 2'b00);
      @(negedge clk) rx_enable = 1'b1;
      rx_mode = 2'b00;
      cyc(1, 8, 4'b1111, 0, 0, 0); check("R11 policy off", 2'b00);

      // R9: special persistence
      rx_mode = 2'b10; parity_en = 1'b0;
      cyc(1, 1, 4'b1000, 0, 0, 0); check("R9 overrun", 2'b10);
      cyc(0, 0, 4'b0000, 1, 0, 0); check("R9 ack keeps special", 2'b10);
      cyc(1, 2, 4'b0000, 0, 0, 0); check("R8 special hides char", 2'b10);
      cyc(0, 0, 4'b0000, 0, 1, 0); check("R9 reveal char", 2'b01);
      cyc(0, 0, 4'b0000, 1, 0, 0); check("R10 final ack", 2'b00);

      // Sweep: R2 R3 R4 R6 R7 R8 R9 R10
      for (int m = 0; m < 4; m++)
         for (int t = 0; t < 2; t++)
            for (int p = 0; p < 2; p++)
               for (int e = 0; e < 16; e++)
                  for (int l = 0; l <= DEPTH; l++) begin
                     logic [3:0] ev;
                     logic sc, ca;
                     logic [1:0] exp;
                     ev = 4'(e);
                     rx_mode = 2'(m); thresh_en = t[0]; parity_en = p[0];
                     sc = (m != 0) && (ev[3] || ev[2] || ev[1] || (ev[0] && p[0]));
                     ca = (m == 1) || (m == 2 && (t == 0 || l >= THR));
                     exp = sc ? 2'b10 : (ca ? 2'b01 : 2'b00);
                     cyc(1, l, ev, 0, 0, 0);
                     check("R3/R6/R7/R8 sweep strobe", exp);
                     cyc(0, 0, 4'b0000, 0, 1, 1);
                     check("R9 sweep after err reset", ca ? 2'b01 : 2'b00);
                     cyc(0, 0, 4'b0000, 1, 0, 0);
                     check("R10 sweep after ack", 2'b00);
                  end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule